// File: doc/BRIEF.md
# Host I/O Write Port Capture

This block listens to a 16-bit host I/O bus and claims writes aimed at one fixed port address. When the address matches and the address-enable line shows that the cycle is not a DMA cycle, the block registers a select on the rising clock edge. It also drives the active-low 16-bit transfer select back to the host. While that select is active and the host pulls its write strobe low, the block copies the bus data into a holding register on the following capture edge. By default the capture edge is the falling edge.

A captured word raises `permit`, which tells a downstream width converter that a word is ready. `permit` stays high until the converter pulses `conv_done`. Until then the block refuses further writes, so the word being converted cannot be overwritten. A synchronous reset returns the select, the flag and the holding register to their idle values.

The port address, the bus widths and the capture edge are parameters.

Top module: `iowr_capture`

## Requirements
- R1: `cs16_n` goes low one rising clock edge after the inputs show `bus_aen` low and `bus_addr` equal to 0x0280 on all 16 bits. It stays high for any other address.
- R2: While `bus_aen` is high, the block claims no cycle. `cs16_n` is high on the following edge and no word is captured.
- R3: If the registered select is active, `bus_iow_n` is low and `permit` is low, the next falling clock edge loads `bus_data` into `word_q` and sets `permit` high.
- R4: Once `permit` is high, it stays high until `conv_done` is sampled high on a falling edge. That edge clears it.
- R5: While `permit` is high, further writes are ignored and `word_q` keeps the word already captured.
- R6: `word_drv` is high exactly while the registered select is active (`cs16_n` low). At all other times the holding register output is to be treated as undriven.
- R7: A synchronous `rst` sets `cs16_n` high and `word_drv` low, clears `permit`, and sets `word_q` to zero.
- R8: With the strobe held high, a matching address raises the select but captures nothing. A strobe during a non-matching cycle also captures nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | 16 | I/O address from the host |
| bus_aen | input | 1 | Address enable; high marks a DMA cycle |
| bus_iow_n | input | 1 | I/O write strobe, active low |
| bus_data | input | 16 | Write data from the host |
| conv_done | input | 1 | Converter finished; releases the held word |
| cs16_n | output | 1 | 16-bit transfer select, active low |
| word_drv | output | 1 | High while the holding register counts as driven |
| word_q | output | 16 | Captured word |
| permit | output | 1 | A word is ready for conversion |

## Verification
The assertions assume that the bus inputs change only away from both clock edges. They also assume that `conv_done` arrives only as a response to `permit`. The stimulus respects both: every input is changed one nanosecond after a rising edge and is held across the next falling edge, and `conv_done` is pulsed only after a capture. The sweep walks every single-bit address neighbour of the port with the DMA line both low and high. This shows that only the exact address, outside DMA cycles, is ever claimed.

// File: rtl/iowr_pkg.sv
package iowr_pkg;
   typedef enum logic {
      EDGE_FALL = 1'b0,
      EDGE_RISE = 1'b1
   } edge_e;

   localparam int unsigned DEF_ADDR_W = 16;
   localparam int unsigned DEF_DATA_W = 16;
endpackage

// File: rtl/iowr_decode.sv
module iowr_decode #(
   parameter int unsigned ADDR_W = 16,
   parameter logic [ADDR_W-1:0] MATCH = 'h0280
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [ADDR_W-1:0] addr,
   input  logic              aen,
   output logic              sel_q
);
   logic [ADDR_W-1:0] bit_ok;

   for (genvar i = 0; i < ADDR_W; i++) begin : g_cmp
      assign bit_ok[i] = ~(addr[i] ^ MATCH[i]);
   end

   always_ff @(posedge clk) begin
      if (rst) sel_q <= 1'b0;
      else     sel_q <= (&bit_ok) & ~aen;
   end
endmodule

// File: rtl/iowr_hold.sv
module iowr_hold #(
   parameter int unsigned DATA_W = 16,
   parameter iowr_pkg::edge_e CAP_EDGE = iowr_pkg::EDGE_FALL
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              sel,
   input  logic              iow_n,
   input  logic [DATA_W-1:0] data,
   input  logic              done,
   output logic [DATA_W-1:0] word_q,
   output logic              permit_q
);
   logic [DATA_W-1:0] word_nx;
   logic              permit_nx;
   logic              take;

   assign take = sel & ~iow_n & ~permit_q;

   always_comb begin
      word_nx   = word_q;
      permit_nx = permit_q;
      if (rst) begin
         word_nx   = '0;
         permit_nx = 1'b0;
      end else if (permit_q) begin
         if (done) permit_nx = 1'b0;
      end else if (take) begin
         word_nx   = data;
         permit_nx = 1'b1;
      end
   end

   if (CAP_EDGE == iowr_pkg::EDGE_FALL) begin : g_fall
      always_ff @(negedge clk) begin
         word_q   <= word_nx;
         permit_q <= permit_nx;
      end
   end else begin : g_rise
      always_ff @(posedge clk) begin
         word_q   <= word_nx;
         permit_q <= permit_nx;
      end
   end
endmodule

// File: rtl/iowr_capture.sv
module iowr_capture #(
   parameter int unsigned ADDR_W = iowr_pkg::DEF_ADDR_W,
   parameter int unsigned DATA_W = iowr_pkg::DEF_DATA_W,
   parameter logic [ADDR_W-1:0] PORT_ADDR = 'h0280,
   parameter iowr_pkg::edge_e CAP_EDGE = iowr_pkg::EDGE_FALL
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_aen,
   input  logic              bus_iow_n,
   input  logic [DATA_W-1:0] bus_data,
   input  logic              conv_done,
   output logic              cs16_n,
   output logic              word_drv,
   output logic [DATA_W-1:0] word_q,
   output logic              permit
);
   if (ADDR_W < 1 || ADDR_W > 32) begin : g_bad_addr_w
      $error("iowr_capture: ADDR_W out of range");
   end
   if (DATA_W < 1 || DATA_W > 64) begin : g_bad_data_w
      $error("iowr_capture: DATA_W out of range");
   end

   logic en_q;

   iowr_decode #(.ADDR_W(ADDR_W), .MATCH(PORT_ADDR)) u_dec (
      .clk(clk), .rst(rst), .addr(bus_addr), .aen(bus_aen), .sel_q(en_q)
   );

   iowr_hold #(.DATA_W(DATA_W), .CAP_EDGE(CAP_EDGE)) u_hold (
      .clk(clk), .rst(rst), .sel(en_q), .iow_n(bus_iow_n), .data(bus_data),
      .done(conv_done), .word_q(word_q), .permit_q(permit)
   );

   assign cs16_n   = ~en_q;
   assign word_drv = en_q;
endmodule

// File: rtl/iowr_capture_chk.sv
module iowr_capture_chk #(
   parameter int unsigned ADDR_W = 16,
   parameter int unsigned DATA_W = 16,
   parameter logic [ADDR_W-1:0] PORT_ADDR = 'h0280,
   parameter iowr_pkg::edge_e CAP_EDGE = iowr_pkg::EDGE_FALL
) (
   input logic              clk,
   input logic              rst,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_aen,
   input logic              bus_iow_n,
   input logic [DATA_W-1:0] bus_data,
   input logic              conv_done,
   input logic              cs16_n,
   input logic [DATA_W-1:0] word_q,
   input logic              permit,
   input logic              en
);
   logic cap_clk;
   assign cap_clk = (CAP_EDGE == iowr_pkg::EDGE_FALL) ? ~clk : clk;

   // R1
   addr_hit_chk: assert property (@(posedge clk) disable iff (rst)
      (!bus_aen && bus_addr == PORT_ADDR) |=> !cs16_n);

   // R2
   dma_skip_chk: assert property (@(posedge clk) disable iff (rst)
      bus_aen |=> cs16_n);

   // R3
   capture_chk: assert property (@(posedge cap_clk) disable iff (rst)
      (!permit && en && !bus_iow_n) |=> (permit && word_q == $past(bus_data)));

   // R4
   permit_hold_chk: assert property (@(posedge cap_clk) disable iff (rst)
      (permit && !conv_done) |=> permit);

   // R4
   permit_clear_chk: assert property (@(posedge cap_clk) disable iff (rst)
      (permit && conv_done) |=> !permit);

   // R5
   word_keep_chk: assert property (@(posedge cap_clk) disable iff (rst)
      permit |=> $stable(word_q));

   // R7
   reset_hold_chk: assert property (@(posedge cap_clk)
      rst |=> (!permit && word_q == '0));

   // R7
   reset_sel_chk: assert property (@(posedge clk)
      rst |=> cs16_n);
endmodule

bind iowr_capture iowr_capture_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PORT_ADDR(PORT_ADDR), .CAP_EDGE(CAP_EDGE)
) u_chk (
   .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_aen(bus_aen),
   .bus_iow_n(bus_iow_n), .bus_data(bus_data), .conv_done(conv_done),
   .cs16_n(cs16_n), .word_q(word_q), .permit(permit), .en(en_q)
);

// File: tb/iowr_capture_test.sv
`timescale 1ns/1ps
module iowr_capture_test;
   localparam logic [15:0] PORT = 16'h0280;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [15:0] bus_addr = '0;
   logic        bus_aen = 1'b1;
   logic        bus_iow_n = 1'b1;
   logic [15:0] bus_data = '0;
   logic        conv_done = 1'b0;
   logic        cs16_n;
   logic        word_drv;
   logic [15:0] word_q;
   logic        permit;

   int checks = 0;
   int errors = 0;
   logic [15:0] exp_word = '0;

   always #4 clk = ~clk;

   iowr_capture uut (
      .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_aen(bus_aen),
      .bus_iow_n(bus_iow_n), .bus_data(bus_data), .conv_done(conv_done),
      .cs16_n(cs16_n), .word_drv(word_drv), .word_q(word_q), .permit(permit)
   );

   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // drive point: 1 ns after a rising edge
   task automatic cyc();
      @(posedge clk);
      #1;
   endtask

   // sample point: after the falling edge of the same cycle
   task automatic look();
      #5;
   endtask

   task automatic idle_bus();
      bus_addr  = '0;
      bus_aen   = 1'b1;
      bus_iow_n = 1'b1;
   endtask

   task automatic release_word();
      cyc(); idle_bus(); conv_done = 1'b1;
      cyc(); conv_done = 1'b0; look();
      chk("R4 permit cleared by done", {15'd0, permit}, 16'd0);
      chk("R6 select idle", {15'd0, cs16_n}, 16'd1);
   endtask

   initial begin
      repeat (3) cyc();
      look();
      chk("R7 reset cs16_n", {15'd0, cs16_n}, 16'd1);
      chk("R7 reset permit", {15'd0, permit}, 16'd0);
      chk("R7 reset word", word_q, 16'd0);
      chk("R7 reset drv", {15'd0, word_drv}, 16'd0);
      cyc(); rst = 1'b0;

      // sweep exact address and all single-bit neighbours, aen low and high
      for (int b = -1; b < 16; b++) begin
         for (int a = 0; a < 2; a++) begin
            logic [15:0] ad;
            logic [15:0] dv;
            logic        hit;
            ad  = (b < 0) ? PORT : (PORT ^ (16'd1 << b));
            dv  = 16'hA5C3 ^ (16'(b + 1) * 16'h1357) ^ (16'(a) * 16'h8001);
            hit = (b < 0) && (a == 0);
            cyc();
            bus_addr = ad; bus_aen = a[0]; bus_data = dv; bus_iow_n = 1'b0;
            cyc(); look();
            if (hit) exp_word = dv;
            chk(a ? "R2 cs16_n under dma" : "R1 cs16_n decode",
                {15'd0, cs16_n}, {15'd0, ~hit});
            chk("R6 drv follows select", {15'd0, word_drv}, {15'd0, hit});
            chk(hit ? "R3 permit on capture" : "R8 no permit on miss",
                {15'd0, permit}, {15'd0, hit});
            chk(hit ? "R3 word captured" : "R8 word kept on miss", word_q, exp_word);
            release_word();
         end
      end

      // select without strobe
      cyc(); bus_addr = PORT; bus_aen = 1'b0; bus_data = 16'h1111;
      cyc(); look();
      chk("R8 select without strobe", {15'd0, cs16_n}, 16'd0);
      chk("R8 no capture without strobe", word_q, exp_word);
      chk("R8 no permit without strobe", {15'd0, permit}, 16'd0);

      // second write while busy
      cyc(); bus_iow_n = 1'b0; bus_data = 16'h2468;
      cyc(); look(); exp_word = 16'h2468;
      chk("R3 capture first", word_q, exp_word);
      cyc(); bus_data = 16'h9BDF;
      cyc(); cyc(); look();
      chk("R5 second write ignored", word_q, exp_word);
      chk("R4 permit held", {15'd0, permit}, 16'd1);
      release_word();
      chk("R5 word kept after release", word_q, exp_word);

      // synchronous reset mid-word
      cyc(); bus_addr = PORT; bus_aen = 1'b0; bus_iow_n = 1'b0; bus_data = 16'h7E7E;
      cyc(); look();
      chk("R3 capture before reset", word_q, 16'h7E7E);
      cyc(); rst = 1'b1; idle_bus();
      cyc(); look();
      chk("R7 reset clears word", word_q, 16'd0);
      chk("R7 reset clears permit", {15'd0, permit}, 16'd0);
      chk("R7 reset releases select", {15'd0, cs16_n}, 16'd1);
      rst = 1'b0;

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #(8 * 200000);
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule